// File: doc/BRIEF.md
# Byte-Addressed Register Slave File

This block is the register file of a peripheral controller. A host reaches it through a byte-level serial slave port that has already been reduced to single-cycle strobes: a start event, a stop event, a written byte and a read request. After a start, the first byte the host writes becomes the register pointer. Each later written byte, and each read request, touches the register under the pointer, after which the pointer moves to the next register. In this way, one access can cover a run of consecutive registers.

The 256 addresses hold several kinds of register. Most are plain storage. A constant version pair and a window of status bytes are read-only; the status bytes are taken live from input ports. One register latches two event flags until the host acknowledges them. Two write-only registers turn the bits the host writes into one-cycle request pulses for power and display hardware. One storage byte sets the timeout of a small watchdog, and some address ranges are empty. The watchdog takes a new timeout only when it is next armed.

Top module: `rsf_regslave`

## Requirements
- R1: After a start, the first written byte loads the register pointer. Each later data write or read uses the pointer and then adds one to it, with 0xFF followed by 0x00.
- R2: Addresses 0x5B to 0x5F, 0x62 to 0x7E and 0x80 to 0xFF read as 0xFF, and writes to them change nothing.
- R3: Address 0x00 reads the upper byte and 0x01 the lower byte of the VERSION parameter (default 0x3A17). Addresses STAT_BASE to STAT_BASE+STAT_N-1 (default 0x08 to 0x0F) return byte i of `status_in` (bits 8i+7..8i) as sampled in the cycle of the read request. Writes to all of these addresses have no effect.
- R4: Address 0x02 reads as zeros in bits 7..2 and the event flags in bits 1..0. A high bit of `evt_set` sets the matching flag. Writing a byte clears each flag whose bit is 1 in that byte. A set and a clear of the same flag in the same cycle leave the flag set.
- R5: During reset, both event flags load the value of `rst_by_wdog`. After a reset with `rst_by_wdog` high, address 0x02 reads 0x03; otherwise it reads 0x00.
- R6: A write to 0x20 drives `pwr_req` with the written byte masked by 0x0F for exactly the one cycle after the write: bit0 requests power-off, and bits 1 and 2 request reboot. The register reads 0x00.
- R7: A write to 0x22 drives `disp_req` with the written byte masked by 0x3F for exactly the one cycle after the write. The register reads 0x00.
- R8: Address 0x24 is read-write and holds the watchdog timeout. An `wd_arm` pulse loads the stored timeout. A zero timeout leaves the watchdog stopped. A nonzero timeout N makes `wd_expire` pulse for one cycle, right after the Nth `wd_tick`, and then stops it. Writing 0x24 while the watchdog runs does not change the countdown in progress.
- R9: A stop ends the access. Until the next start, written bytes and read requests are ignored, and no `rd_valid` is produced. Strobes in the same cycle as a start or stop are ignored.
- R10: Every accepted read request gives `rd_valid` high with the byte on `rd_data` in the following cycle.
- R11: Reset clears all storage registers, the pointer, `rd_valid`, the request pulses and the watchdog.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_by_wdog | input | 1 | Reset cause is the watchdog; loaded into the event flags during reset |
| bus_start | input | 1 | Start (or repeated start) event strobe |
| bus_stop | input | 1 | Stop event strobe |
| wr_valid | input | 1 | Host wrote a byte |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Host requests a byte |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| status_in | input | STAT_N*8 | Live status bytes for the read-only window |
| evt_set | input | 2 | Event flag set pulses (bit0 clock defaults restored, bit1 watchdog reset) |
| pwr_req | output | 4 | Power control request pulses |
| disp_req | output | 6 | Display control request pulses |
| wd_arm | input | 1 | Arm the watchdog with the stored timeout |
| wd_tick | input | 1 | Watchdog count tick |
| wd_running | output | 1 | Watchdog countdown active |
| wd_expire | output | 1 | Watchdog timeout pulse |

## Verification
A corrupted address classification shows at the ports on the very next read. Such a read of a hole returns something other than 0xFF, or a read of a command register returns something other than 0x00. A sweep that reads and then writes every one of the 256 addresses, in a single access that wraps around, therefore exposes it within one pass. A pointer that drifts or fails to wrap misplaces every later byte of the same access. A stuck command pulse or event flag is seen one cycle after the write that should have produced or cleared it. A watchdog that reloads at the wrong time shifts the `wd_expire` pulse away from the exact tick count.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

    localparam int ADDR_W = 8;
    localparam int EVT_W  = 2;
    localparam int PWR_W  = 4;
    localparam int DISP_W = 6;

    localparam logic [ADDR_W-1:0] A_VER_HI = 8'h00;
    localparam logic [ADDR_W-1:0] A_VER_LO = 8'h01;
    localparam logic [ADDR_W-1:0] A_EVT    = 8'h02;
    localparam logic [ADDR_W-1:0] A_PWR    = 8'h20;
    localparam logic [ADDR_W-1:0] A_DISP   = 8'h22;
    localparam logic [ADDR_W-1:0] A_WDOG   = 8'h24;

    typedef enum logic [2:0] {
        K_RW, K_VER_HI, K_VER_LO, K_STAT, K_EVT, K_PWR, K_DISP, K_HOLE
    } reg_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_PTR, PH_DATA
    } phase_e;

    // Map an address to the kind of register that lives there.
    function automatic reg_kind_e classify(input logic [ADDR_W-1:0] a,
                                           input int sbase, input int sn);
        int ai;
        ai = int'(a);
        if ((ai >= 'h5B && ai <= 'h5F) || (ai >= 'h62 && ai <= 'h7E) || ai >= 'h80)
            return K_HOLE;
        if (a == A_VER_HI) return K_VER_HI;
        if (a == A_VER_LO) return K_VER_LO;
        if (a == A_EVT)    return K_EVT;
        if (a == A_PWR)    return K_PWR;
        if (a == A_DISP)   return K_DISP;
        if (ai >= sbase && ai < sbase + sn) return K_STAT;
        return K_RW;
    endfunction

endpackage

// File: rtl/rsf_frame.sv
module rsf_frame
    import rsf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_byte,
    input  logic              rd_req,
    output logic              acc_wr,
    output logic              acc_rd,
    output logic [ADDR_W-1:0] acc_addr
);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] ptr;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   quiet;

    always_comb begin
        quiet    = !bus_start && !bus_stop;
        acc_wr   = quiet && wr_valid && (fr_q.phase == PH_DATA);
        acc_rd   = quiet && rd_req && !wr_valid && (fr_q.phase != PH_IDLE);
        acc_addr = fr_q.ptr;

        fr_d = fr_q;
        if (bus_start) begin
            fr_d.phase = PH_PTR;
        end else if (bus_stop) begin
            fr_d.phase = PH_IDLE;
        end else if (wr_valid && fr_q.phase == PH_PTR) begin
            fr_d.ptr   = wr_byte;
            fr_d.phase = PH_DATA;
        end else if (acc_wr || acc_rd) begin
            fr_d.ptr = fr_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fr_q.phase <= PH_IDLE;
            fr_q.ptr   <= '0;
        end else begin
            fr_q <= fr_d;
        end
    end

endmodule

// File: rtl/rsf_regs.sv
module rsf_regs
    import rsf_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [2*DW-1:0] VERSION   = 16'h3A17,
    parameter int              STAT_BASE = 8,
    parameter int              STAT_N    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_by_wdog,
    input  logic                 acc_wr,
    input  logic                 acc_rd,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [DW-1:0]        wr_data,
    input  logic [STAT_N*DW-1:0] status_in,
    input  logic [EVT_W-1:0]     evt_set,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    output logic [PWR_W-1:0]     pwr_req,
    output logic [DISP_W-1:0]    disp_req,
    output logic [DW-1:0]        wd_timeout
);

    localparam int NREG = 1 << ADDR_W;

    typedef struct packed {
        logic [EVT_W-1:0]  evt;
        logic [PWR_W-1:0]  pwr;
        logic [DISP_W-1:0] disp;
        logic              rv;
        logic [DW-1:0]     rd;
    } regs_t;

    regs_t         st_d, st_q;
    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];
    reg_kind_e     kind;
    logic [DW-1:0] rd_val;
    logic [EVT_W-1:0] evt_clr;
    int            sbit;

    always_comb begin
        kind = classify(acc_addr, STAT_BASE, STAT_N);
        sbit = 0;

        // read multiplexer
        case (kind)
            K_HOLE:   rd_val = '1;
            K_VER_HI: rd_val = VERSION[2*DW-1:DW];
            K_VER_LO: rd_val = VERSION[DW-1:0];
            K_STAT: begin
                sbit   = (int'(acc_addr) - STAT_BASE) * DW;
                rd_val = status_in[sbit +: DW];
            end
            K_EVT:    rd_val = DW'(st_q.evt);
            K_PWR,
            K_DISP:   rd_val = '0;
            default:  rd_val = mem_q[acc_addr];
        endcase

        // storage writes: only plain registers accept data
        for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
        if (acc_wr && kind == K_RW) mem_d[acc_addr] = wr_data;

        st_d = st_q;
        evt_clr = (acc_wr && kind == K_EVT) ? wr_data[EVT_W-1:0] : '0;
        st_d.evt  = (st_q.evt & ~evt_clr) | evt_set;
        st_d.pwr  = (acc_wr && kind == K_PWR)  ? wr_data[PWR_W-1:0]  : '0;
        st_d.disp = (acc_wr && kind == K_DISP) ? wr_data[DISP_W-1:0] : '0;
        st_d.rv   = acc_rd;
        st_d.rd   = acc_rd ? rd_val : st_q.rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.evt  <= {EVT_W{rst_by_wdog}};
            st_q.pwr  <= '0;
            st_q.disp <= '0;
            st_q.rv   <= 1'b0;
            st_q.rd   <= '0;
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else begin
            st_q <= st_d;
            for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_valid   = st_q.rv;
    assign rd_data    = st_q.rd;
    assign pwr_req    = st_q.pwr;
    assign disp_req   = st_q.disp;
    assign wd_timeout = mem_q[A_WDOG];

endmodule

// File: rtl/rsf_wdog.sv
module rsf_wdog #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic         tick,
    input  logic [W-1:0] timeout,
    output logic         running,
    output logic         expire
);

    typedef struct packed {
        logic         run;
        logic [W-1:0] cnt;
        logic         exp;
    } wdog_t;

    wdog_t wd_d, wd_q;

    always_comb begin
        wd_d     = wd_q;
        wd_d.exp = 1'b0;
        if (arm) begin
            // the timeout is captured only here
            wd_d.run = (timeout != '0);
            wd_d.cnt = timeout;
        end else if (wd_q.run && tick) begin
            if (wd_q.cnt == W'(1)) begin
                wd_d.run = 1'b0;
                wd_d.exp = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign running = wd_q.run;
    assign expire  = wd_q.exp;

endmodule

// File: rtl/rsf_regslave.sv
module rsf_regslave
    import rsf_pkg::*;
#(
    parameter int              DW        = 8,
    parameter logic [2*DW-1:0] VERSION   = 16'h3A17,
    parameter int              STAT_BASE = 8,
    parameter int              STAT_N    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_by_wdog,
    input  logic                 bus_start,
    input  logic                 bus_stop,
    input  logic                 wr_valid,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_req,
    output logic                 rd_valid,
    output logic [DW-1:0]        rd_data,
    input  logic [STAT_N*DW-1:0] status_in,
    input  logic [EVT_W-1:0]     evt_set,
    output logic [PWR_W-1:0]     pwr_req,
    output logic [DISP_W-1:0]    disp_req,
    input  logic                 wd_arm,
    input  logic                 wd_tick,
    output logic                 wd_running,
    output logic                 wd_expire
);

    logic              acc_wr;
    logic              acc_rd;
    logic [ADDR_W-1:0] acc_addr;
    logic [DW-1:0]     wd_timeout;

    rsf_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .wr_valid  (wr_valid),
        .wr_byte   (wr_data[ADDR_W-1:0]),
        .rd_req    (rd_req),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .acc_addr  (acc_addr)
    );

    rsf_regs #(
        .DW        (DW),
        .VERSION   (VERSION),
        .STAT_BASE (STAT_BASE),
        .STAT_N    (STAT_N)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_by_wdog (rst_by_wdog),
        .acc_wr      (acc_wr),
        .acc_rd      (acc_rd),
        .acc_addr    (acc_addr),
        .wr_data     (wr_data),
        .status_in   (status_in),
        .evt_set     (evt_set),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .pwr_req     (pwr_req),
        .disp_req    (disp_req),
        .wd_timeout  (wd_timeout)
    );

    rsf_wdog #(
        .W (DW)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (wd_arm),
        .tick    (wd_tick),
        .timeout (wd_timeout),
        .running (wd_running),
        .expire  (wd_expire)
    );

endmodule

// File: rtl/rsf_regslave_chk.sv
module rsf_regslave_chk
    import rsf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_stop,
    input logic              wr_valid,
    input logic              rd_req,
    input logic              rd_valid,
    input logic [PWR_W-1:0]  pwr_req,
    input logic [DISP_W-1:0] disp_req,
    input logic              wd_tick,
    input logic              wd_running,
    input logic              wd_expire
);

    // R10: read data only follows a read request
    p_rd_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));

    // R9: a read request in the stop cycle yields nothing
    p_stop_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !rd_valid);

    // R6: power request lasts one cycle and comes from a write
    p_pwr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req != '0) |=> (pwr_req == '0));
    p_pwr_from_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req != '0) |-> $past(wr_valid));

    // R7: display request lasts one cycle and comes from a write
    p_disp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req != '0) |=> (disp_req == '0));
    p_disp_from_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_req != '0) |-> $past(wr_valid));

    // R8: expiry only ends a running countdown on a tick
    p_expire_from_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |-> ($past(wd_running) && $past(wd_tick) && !wd_running));
    p_expire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_expire |=> !wd_expire);

endmodule

bind rsf_regslave rsf_regslave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_stop   (bus_stop),
    .wr_valid   (wr_valid),
    .rd_req     (rd_req),
    .rd_valid   (rd_valid),
    .pwr_req    (pwr_req),
    .disp_req   (disp_req),
    .wd_tick    (wd_tick),
    .wd_running (wd_running),
    .wd_expire  (wd_expire)
);

// File: tb/rsf_regslave_tb.sv
module rsf_regslave_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_by_wdog = 1'b0;
    logic        bus_start = 1'b0;
    logic        bus_stop = 1'b0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_req = 1'b0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [63:0] status_in = 64'h8877665544332211;
    logic [1:0]  evt_set = '0;
    logic [3:0]  pwr_req;
    logic [5:0]  disp_req;
    logic        wd_arm = 1'b0;
    logic        wd_tick = 1'b0;
    logic        wd_running;
    logic        wd_expire;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    rsf_regslave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_by_wdog (rst_by_wdog),
        .bus_start   (bus_start),
        .bus_stop    (bus_stop),
        .wr_valid    (wr_valid),
        .wr_data     (wr_data),
        .rd_req      (rd_req),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .status_in   (status_in),
        .evt_set     (evt_set),
        .pwr_req     (pwr_req),
        .disp_req    (disp_req),
        .wd_arm      (wd_arm),
        .wd_tick     (wd_tick),
        .wd_running  (wd_running),
        .wd_expire   (wd_expire)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic bit is_hole(input int a);
        return (a >= 'h5B && a <= 'h5F) || (a >= 'h62 && a <= 'h7E) || a >= 'h80;
    endfunction

    // expected read value from the requirements
    function automatic logic [7:0] expect_rd(input int a, input logic [7:0] rw,
                                             input logic [1:0] ev, input logic [63:0] st);
        if (is_hole(a))           return 8'hFF;
        if (a == 0)               return 8'h3A;
        if (a == 1)               return 8'h17;
        if (a == 2)               return {6'b0, ev};
        if (a >= 8 && a <= 15)    return st[(a-8)*8 +: 8];
        if (a == 'h20 || a == 'h22) return 8'h00;
        return rw;
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic bus_begin(input logic [7:0] ptr);
        bus_start = 1'b1; cyc(); bus_start = 1'b0;
        wr_valid = 1'b1; wr_data = ptr; cyc(); wr_valid = 1'b0;
    endtask

    task automatic bus_end();
        bus_stop = 1'b1; cyc(); bus_stop = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] d);
        wr_valid = 1'b1; wr_data = d; cyc(); wr_valid = 1'b0;
    endtask

    task automatic rbyte(output logic v, output logic [7:0] d);
        rd_req = 1'b1; cyc(); rd_req = 1'b0;
        v = rd_valid; d = rd_data;
    endtask

    task automatic wtick();
        wd_tick = 1'b1; cyc(); wd_tick = 1'b0;
    endtask

    task automatic warm();
        wd_arm = 1'b1; cyc(); wd_arm = 1'b0;
    endtask

    task automatic do_reset(input logic cause);
        rst_by_wdog = cause; rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1; rst_by_wdog = 1'b0;
        cyc();
    endtask

    task automatic read_at(input logic [7:0] a, output logic [7:0] d);
        logic v;
        bus_begin(a); rbyte(v, d); bus_end();
        chk("R10 rd_valid", 32'(v), 32'd1);
    endtask

    task automatic write_at(input logic [7:0] a, input logic [7:0] d);
        bus_begin(a); wbyte(d); bus_end();
    endtask

    initial begin
        logic       v;
        logic [7:0] d;

        do_reset(1'b0);
        // R11 reset state
        chk("R11 rd_valid", 32'(rd_valid), 0);
        chk("R11 pwr_req", 32'(pwr_req), 0);
        chk("R11 disp_req", 32'(disp_req), 0);
        chk("R11 wd_running", 32'(wd_running), 0);
        chk("R11 wd_expire", 32'(wd_expire), 0);

        // R1 R2 R3 R5 R11 full read sweep after reset, one access
        bus_begin(8'h00);
        for (int a = 0; a < 256; a++) begin
            rbyte(v, d);
            chk("R10 sweep valid", 32'(v), 1);
            chk($sformatf("R1/R2/R3 read %0h", a), 32'(d),
                32'(expect_rd(a, 8'h00, 2'b00, status_in)));
        end
        bus_end();

        // R1 R2 R3 write sweep across all addresses, then read back
        bus_begin(8'h00);
        for (int a = 0; a < 256; a++) wbyte(pat(a));
        bus_end();
        bus_begin(8'h00);
        for (int a = 0; a < 256; a++) begin
            rbyte(v, d);
            chk($sformatf("R1/R2/R3 readback %0h", a), 32'(d),
                32'(expect_rd(a, pat(a), 2'b00, status_in)));
        end
        bus_end();

        // R1 pointer wrap on reads
        bus_begin(8'hFE);
        rbyte(v, d); chk("R1 wrap FE", 32'(d), 32'hFF);
        rbyte(v, d); chk("R1 wrap FF", 32'(d), 32'hFF);
        rbyte(v, d); chk("R1 wrap 00", 32'(d), 32'h3A);
        rbyte(v, d); chk("R1 wrap 01", 32'(d), 32'h17);
        bus_end();
        // R1 wrap on writes: FF hole then 00 read-only, 03 gets data
        bus_begin(8'hFF);
        wbyte(8'h11); wbyte(8'h22); wbyte(8'h33); wbyte(8'h44); wbyte(8'h55);
        bus_end();
        read_at(8'h00, d); chk("R3 version write ignored", 32'(d), 32'h3A);
        read_at(8'h03, d); chk("R1 wrap write 03", 32'(d), 32'h55);

        // R3 status sampled live
        status_in[31:24] = 8'hC3;
        read_at(8'h0B, d); chk("R3 live status", 32'(d), 32'hC3);

        // R4 event flags
        evt_set = 2'b01; cyc(); evt_set = 2'b00;
        read_at(8'h02, d); chk("R4 set bit0", 32'(d), 32'h01);
        evt_set = 2'b10; cyc(); evt_set = 2'b00;
        read_at(8'h02, d); chk("R4 set bit1", 32'(d), 32'h03);
        write_at(8'h02, 8'hFD);
        read_at(8'h02, d); chk("R4 clear bit0", 32'(d), 32'h02);
        write_at(8'h02, 8'h02);
        read_at(8'h02, d); chk("R4 clear bit1", 32'(d), 32'h00);
        bus_begin(8'h02);
        evt_set = 2'b01; wbyte(8'h01); evt_set = 2'b00;
        bus_end();
        read_at(8'h02, d); chk("R4 set wins", 32'(d), 32'h01);

        // R6 power pulses
        bus_begin(8'h20); wbyte(8'hFF);
        chk("R6 pulse masked", 32'(pwr_req), 32'h0F);
        cyc();
        chk("R6 pulse one cycle", 32'(pwr_req), 0);
        bus_end();
        bus_begin(8'h20); wbyte(8'h35);
        chk("R6 pulse pattern", 32'(pwr_req), 32'h05);
        bus_end();
        read_at(8'h20, d); chk("R6 reads zero", 32'(d), 0);

        // R7 display pulses
        bus_begin(8'h22); wbyte(8'hFF);
        chk("R7 pulse masked", 32'(disp_req), 32'h3F);
        cyc();
        chk("R7 pulse one cycle", 32'(disp_req), 0);
        bus_end();
        bus_begin(8'h22); wbyte(8'hAA);
        chk("R7 pulse pattern", 32'(disp_req), 32'h2A);
        bus_end();
        read_at(8'h22, d); chk("R7 reads zero", 32'(d), 0);

        // R9 stop ends access
        write_at(8'h30, 8'h77);
        wbyte(8'h99);
        rbyte(v, d); chk("R9 read after stop", 32'(v), 0);
        bus_begin(8'h30);
        rbyte(v, d); chk("R9 write after stop ignored", 32'(d), 32'h77);
        rbyte(v, d); chk("R9 next register", 32'(d), 32'(pat('h31)));
        bus_end();

        // R8 watchdog
        write_at(8'h24, 8'd5);
        read_at(8'h24, d); chk("R8 timeout readback", 32'(d), 5);
        warm();
        chk("R8 running", 32'(wd_running), 1);
        for (int t = 1; t < 5; t++) begin
            wtick(); chk("R8 no early expire", 32'(wd_expire), 0);
        end
        wtick(); chk("R8 expire at N", 32'(wd_expire), 1);
        cyc();
        chk("R8 expire one cycle", 32'(wd_expire), 0);
        chk("R8 stopped", 32'(wd_running), 0);

        write_at(8'h24, 8'd10);
        warm();
        write_at(8'h24, 8'd3);
        for (int t = 1; t < 10; t++) begin
            wtick(); chk("R8 old value kept", 32'(wd_expire), 0);
        end
        wtick(); chk("R8 expire at old N", 32'(wd_expire), 1);

        write_at(8'h24, 8'd0);
        warm();
        chk("R8 zero disables", 32'(wd_running), 0);
        for (int t = 0; t < 20; t++) begin
            wtick(); chk("R8 no expire disabled", 32'(wd_expire), 0);
        end

        // R5 reset caused by watchdog
        do_reset(1'b1);
        read_at(8'h02, d); chk("R5 event after wdog reset", 32'(d), 32'h03);
        read_at(8'h30, d); chk("R11 storage cleared", 32'(d), 0);
        do_reset(1'b0);
        read_at(8'h02, d); chk("R5 event after plain reset", 32'(d), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule